// File: doc/BRIEF.md
# Polarity-Selectable Phase-Frequency Detector

This block compares a reference pulse train with a feedback pulse train. It reports the phase and frequency error on one three-state error line, given here as a data bit and an output-enable. Both inputs are asynchronous to the system clock. Each input passes through a synchronizer chain of configurable depth, then through a rising-edge detector.

A four-state machine keeps one flag per input:

- **IDLE**: neither flag is set.
- **REF_LEAD**: only the reference flag is set.
- **FB_LEAD**: only the feedback flag is set.
- **OVERLAP**: both flags are set. This state lasts one clock.

The transitions are:

- **arm_ref** (IDLE to REF_LEAD): a reference edge arrives alone.
- **arm_fb** (IDLE to FB_LEAD): a feedback edge arrives alone.
- **arm_both** (IDLE to OVERLAP): both edges arrive together.
- **catch_fb** (REF_LEAD to OVERLAP): a feedback edge arrives.
- **catch_ref** (FB_LEAD to OVERLAP): a reference edge arrives.
- **rearm** (OVERLAP to any state): both flags clear, and the edges seen in that same clock set them again.

Because both flags stay set for one clock, a zero phase error still produces a pulse on the up and down indications. The detector therefore has no dead zone.

The error line is driven only while exactly one flag is set. A polarity input selects which of the two leads drives high. With polarity low, a lagging feedback drives high and a leading feedback drives low. With polarity high, the sense is reversed. Separate up (reference flag) and down (feedback flag) outputs are brought out for checking. Each input must stay high for at least one clock and low for at least one clock between edges.

Top module: `pol_pfd`

## Requirements
- R1: While reset is asserted, and after it is released with both inputs low, `up`, `dn`, `err_oe` and `err_q` are all 0 (state IDLE).
- R2: An input level present at a clock edge reaches the detector after SYNC_STAGES further edges. A rising edge changes `up`/`dn` at the SYNC_STAGES+1-th clock edge after it is first sampled.
- R3: A reference edge seen alone sets `up` = 1. `up` stays 1 until a feedback edge is seen.
- R4: A feedback edge seen alone sets `dn` = 1. `dn` stays 1 until a reference edge is seen.
- R5: When the second flag is set, `up` and `dn` are both 1 for exactly one clock. Both then clear, except where a new edge in that clock sets its flag again.
- R6: Further rising edges on an input whose flag is already set have no effect. An input held high produces no further edges.
- R7: `err_oe` is 1 exactly when one of `up`/`dn` is 1 and the other is 0.
- R8: While `err_oe` is 1, `err_q` = `up` XOR `pol`. With `pol` = 0, reference-only drives 1 and feedback-only drives 0. `pol` acts in the same cycle it changes.
- R9: While `err_oe` is 0, `err_q` is 0.
- R10: Rising edges seen on both inputs in the same clock go straight from IDLE to OVERLAP. `up` and `dn` pulse together for one clock, and `err_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse train (asynchronous) |
| fb_in | input | 1 | Feedback pulse train (asynchronous) |
| pol | input | 1 | Polarity select: 0 means lagging feedback drives high |
| err_q | output | 1 | Error line data value |
| err_oe | output | 1 | Error line drive enable (0 = high impedance) |
| up | output | 1 | Reference flag |
| dn | output | 1 | Feedback flag |

## Verification
The bench builds the detector with SYNC_STAGES = 3 instead of the default 2. This checks that the edge-to-flag latency follows the parameter rather than a fixed two-stage chain. A cycle-exact reference model, delayed by that depth, is compared with the outputs every clock. The directed sequences cover each lead, repeated edges on an armed input, coincident edges, and polarity flips while the line is driven. Long random pulse trains then reach edges that land exactly in the overlap clock.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Bit 0 is the reference flag and bit 1 is the feedback flag.
    typedef enum logic [1:0] {
        PFD_IDLE     = 2'b00,
        PFD_REF_LEAD = 2'b01,
        PFD_FB_LEAD  = 2'b10,
        PFD_OVERLAP  = 2'b11
    } pfd_state_e;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev;

endmodule

// File: rtl/pfd_state_core.sv
module pfd_state_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_rise,
    input  logic       fb_rise,
    output pfd_state_e state,
    output logic       up,
    output logic       dn
);
    pfd_state_e nxt;

    // Next-state logic.
    always_comb begin
        nxt = state;
        unique case (state)
            PFD_IDLE, PFD_OVERLAP: begin
                // OVERLAP clears both flags; edges in this clock set them again.
                if (ref_rise && fb_rise) nxt = PFD_OVERLAP;
                else if (ref_rise)       nxt = PFD_REF_LEAD;
                else if (fb_rise)        nxt = PFD_FB_LEAD;
                else                     nxt = PFD_IDLE;
            end
            PFD_REF_LEAD: begin
                if (fb_rise) nxt = PFD_OVERLAP;
            end
            PFD_FB_LEAD: begin
                if (ref_rise) nxt = PFD_OVERLAP;
            end
            default: nxt = PFD_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PFD_IDLE;
        else        state <= nxt;
    end

    // Flag outputs decoded from the state.
    always_comb begin
        up = 1'b0;
        dn = 1'b0;
        unique case (state)
            PFD_IDLE:     begin up = 1'b0; dn = 1'b0; end
            PFD_REF_LEAD: begin up = 1'b1; dn = 1'b0; end
            PFD_FB_LEAD:  begin up = 1'b0; dn = 1'b1; end
            PFD_OVERLAP:  begin up = 1'b1; dn = 1'b1; end
            default:      begin up = 1'b0; dn = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pfd_drive_map.sv
module pfd_drive_map
    import pfd_pkg::*;
(
    input  pfd_state_e state,
    input  logic       pol,
    output logic       err_q,
    output logic       err_oe
);
    always_comb begin
        err_q  = 1'b0;
        err_oe = 1'b0;
        unique case (state)
            PFD_REF_LEAD: begin err_oe = 1'b1; err_q = ~pol; end
            PFD_FB_LEAD:  begin err_oe = 1'b1; err_q = pol;  end
            PFD_IDLE, PFD_OVERLAP: begin err_oe = 1'b0; err_q = 1'b0; end
            default:      begin err_oe = 1'b0; err_q = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pol_pfd.sv
module pol_pfd
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic pol,
    output logic err_q,
    output logic err_oe,
    output logic up,
    output logic dn
);
    logic       ref_rise;
    logic       fb_rise;
    pfd_state_e state;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst_n(rst_n), .din(ref_in), .rise(ref_rise)
    );

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
        .clk(clk), .rst_n(rst_n), .din(fb_in), .rise(fb_rise)
    );

    pfd_state_core u_core (
        .clk(clk), .rst_n(rst_n),
        .ref_rise(ref_rise), .fb_rise(fb_rise),
        .state(state), .up(up), .dn(dn)
    );

    pfd_drive_map u_map (
        .state(state), .pol(pol), .err_q(err_q), .err_oe(err_oe)
    );

endmodule

// File: rtl/pol_pfd_chk.sv
module pol_pfd_chk (
    input logic clk,
    input logic rst_n,
    input logic pol,
    input logic err_q,
    input logic err_oe,
    input logic up,
    input logic dn
);
    // R1: everything is quiet while reset is held.
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!up && !dn && !err_oe && !err_q)
                else $error("R1 outputs active in reset");
        end
    end

    // R3: a lone reference flag holds until the feedback edge.
    a_r3_ref_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn) |=> up);

    // R4: a lone feedback flag holds until the reference edge.
    a_r4_fb_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dn && !up) |=> dn);

    // R5: the overlap lasts a single clock.
    a_r5_overlap_once: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> !(up && dn));

    // R7: the line is driven exactly when one flag is set.
    a_r7_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        err_oe == (up != dn));

    // R8: the driven level follows the set flag and the polarity.
    a_r8_level: assert property (@(posedge clk) disable iff (!rst_n)
        err_oe |-> (err_q == (up ^ pol)));

    // R9: the data bit is zero while not driven.
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !err_oe |-> !err_q);

endmodule

bind pol_pfd pol_pfd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pol(pol),
    .err_q(err_q), .err_oe(err_oe), .up(up), .dn(dn)
);

// File: tb/tb_pol_pfd.sv
`timescale 1ns/1ps
module tb_pol_pfd;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic fb_in = 1'b0;
    logic pol = 1'b0;
    logic err_q, err_oe, up, dn;

    int vectors = 0;
    int fails = 0;

    // Reference model: per-input delay line, then the two flags.
    logic [S:0] hr = '0;
    logic [S:0] hf = '0;
    logic m_up = 1'b0;
    logic m_dn = 1'b0;

    always #10 clk = ~clk;

    pol_pfd #(.SYNC_STAGES(S)) dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in), .pol(pol),
        .err_q(err_q), .err_oe(err_oe), .up(up), .dn(dn)
    );

    function automatic logic exp_oe(input logic u, input logic d);
        return u ^ d;
    endfunction

    function automatic logic exp_q(input logic u, input logic d, input logic p);
        return (u ^ d) ? (u ^ p) : 1'b0;
    endfunction

    task automatic model_step(input logic r, input logic f);
        logic rr;
        logic rf;
        rr = hr[S-1] & ~hr[S];
        rf = hf[S-1] & ~hf[S];
        if (m_up && m_dn) begin
            m_up = rr;
            m_dn = rf;
        end else begin
            m_up = m_up | rr;
            m_dn = m_dn | rf;
        end
        hr = {hr[S-1:0], r};
        hf = {hf[S-1:0], f};
    endtask

    task automatic check(input string tag);
        logic eo;
        logic eq;
        eo = exp_oe(m_up, m_dn);
        eq = exp_q(m_up, m_dn, pol);
        vectors++;
        if (up !== m_up || dn !== m_dn) begin
            fails++;
            $display("FAIL %s up/dn got %b%b exp %b%b", tag, up, dn, m_up, m_dn);
        end else if (err_oe !== eo) begin
            fails++;
            $display("FAIL R7 err_oe got %b exp %b (%s)", err_oe, eo, tag);
        end else if (err_q !== eq) begin
            fails++;
            if (eo) $display("FAIL R8 err_q got %b exp %b (%s)", err_q, eq, tag);
            else    $display("FAIL R9 err_q got %b exp %b (%s)", err_q, eq, tag);
        end
    endtask

    task automatic run(input int n, input logic r, input logic f,
                       input logic p, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag);
            ref_in = r;
            fb_in  = f;
            pol    = p;
            model_step(r, f);
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic rv;
        logic fv;
        logic pv;
        int rc;
        int fc;
        void'($urandom(32'h1357));

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1");
        end
        rst_n = 1'b1;
        run(6, 0, 0, 0, "R1");

        // R2: a one-cycle pulse is caught after the synchronizer depth
        run(1, 1, 0, 0, "R2");
        run(7, 0, 0, 0, "R2");
        run(1, 0, 1, 0, "R2");
        run(7, 0, 0, 0, "R2");

        // R3: reference leads and holds
        run(2, 1, 0, 0, "R3");
        run(8, 0, 0, 0, "R3");
        // R6: second reference edge while armed is ignored
        run(2, 1, 0, 0, "R6");
        run(8, 0, 0, 0, "R6");
        // R5: feedback completes the overlap
        run(2, 0, 1, 0, "R5");
        run(8, 0, 0, 0, "R5");

        // R4: feedback leads, polarity flips while driven
        run(2, 0, 1, 0, "R4");
        run(6, 0, 0, 0, "R4");
        run(4, 0, 0, 1, "R8");
        run(6, 0, 0, 1, "R6");
        run(2, 1, 0, 1, "R5");
        run(8, 0, 0, 1, "R5");

        // R10: coincident edges
        run(2, 1, 1, 0, "R10");
        run(8, 0, 0, 0, "R10");

        // R8: reference leads under inverted polarity
        run(2, 1, 0, 1, "R8");
        run(6, 0, 0, 1, "R8");
        run(3, 0, 0, 0, "R8");
        run(2, 0, 1, 0, "R9");
        run(8, 0, 0, 0, "R9");

        // Random pulse trains
        rv = 1'b0; fv = 1'b0; pv = 1'b0; rc = 1; fc = 1;
        for (int i = 0; i < 6000; i++) begin
            rc--;
            fc--;
            if (rc <= 0) begin rv = ~rv; rc = int'($urandom_range(1, 6)); end
            if (fc <= 0) begin fv = ~fv; fc = int'($urandom_range(1, 6)); end
            if ($urandom_range(0, 49) == 0) pv = ~pv;
            run(1, rv, fv, pv, "R7");
        end
        run(10, 0, 0, 0, "R7");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule